// File: doc/BRIEF.md
# Branch and Subroutine Sequencer

This block keeps the program counter of a small processor and works out the address of the next fetch. A decoded control-transfer request arrives alongside the current instruction. The request carries a kind (jump, call, return or skip), a condition selector, a target mode and an immediate operand. The sequencer tests the selected condition against a registered flag vector from the ALU. It forms a target from one of four sources and loads the program counter on the next clock edge.

Calls save their return address in a small hardware stack, and returns take it back in last-in, first-out order. A conditional skip steps over the following instruction. A skip followed by an unconditional jump or call therefore builds a conditional transfer. A link register and a count register can serve as indirect targets. Both are written through their own load ports. Stack overflow and underflow are each reported on their own sticky error output.

Top module: `bseq_top`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the link register, the count register, the return stack and both error outputs.
- R2: In a cycle without a valid request, the program counter advances by one, modulo 2^ADDR_W.
- R3: `req_mode` picks the target: 0 = program counter plus `req_imm` (two's complement, wrapping), 1 = `req_imm` as an absolute address, 2 = link register, 3 = count register.
- R4: `req_cond` selects the condition: 0 always, 1 zero flag set, 2 zero flag clear, 3 carry set, 4 negative set, 5 overflow set, 6 and 7 never. The flag bits are `flags_in[0]` zero, `[1]` carry, `[2]` negative and `[3]` overflow.
- R5: When the condition fails, the request has no effect: the next address is the program counter plus one and the stack is left unchanged.
- R6: A taken call (`req_kind` 1) pushes the program counter plus one onto the stack and loads the program counter with the target. A taken jump (`req_kind` 0) only loads the target.
- R7: A taken return (`req_kind` 2) loads the program counter with the most recently pushed address and pops it; `req_mode` and `req_imm` are ignored.
- R8: A skip (`req_kind` 3) whose condition holds sets the program counter to its current value plus two.
- R9: A call whose condition holds while the stack holds STACK_DEPTH entries does not push. It sets `ovf_err`, which stays set until reset, and the program counter advances by one.
- R10: A return whose condition holds while the stack is empty does not pop. It sets `unf_err`, which stays set until reset, and the program counter advances by one.
- R11: `taken` is high, in the same cycle as the request, exactly when a valid request's condition holds and it causes no stack error.
- R12: `lr_we` and `ctr_we` load the link and count registers on the clock edge. The new value is the one a later request sees.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A control-transfer request is present for the current instruction |
| req_kind | input | 2 | 0 jump, 1 call, 2 return, 3 skip |
| req_cond | input | 3 | Condition selector |
| req_mode | input | 2 | Target source selector |
| req_imm | input | ADDR_W | Offset or absolute address |
| flags_in | input | 4 | Registered flags: zero, carry, negative, overflow |
| lr_we | input | 1 | Link register load enable |
| lr_wdata | input | ADDR_W | Link register load value |
| ctr_we | input | 1 | Count register load enable |
| ctr_wdata | input | ADDR_W | Count register load value |
| fetch_addr | output | ADDR_W | Current program counter, the address being fetched |
| taken | output | 1 | Current request transfers control |
| ovf_err | output | 1 | Sticky return-stack overflow |
| unf_err | output | 1 | Sticky return-stack underflow |

## Verification
The bench builds the sequencer with an 8-bit address and a four-entry stack. The narrow address lets relative and sequential steps wrap past the top of the address space within a few cycles. The shallow stack reaches the overflow boundary after four nested calls. Directed sequences then cover each mode, condition and kind, the full and empty stack edges, and a long mixed random run checked against a queue-based model.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        XK_JUMP = 2'd0,
        XK_CALL = 2'd1,
        XK_RET  = 2'd2,
        XK_SKIP = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        TM_REL = 2'd0,
        TM_ABS = 2'd1,
        TM_LNK = 2'd2,
        TM_CNT = 2'd3
    } tgt_mode_e;

    typedef enum logic [2:0] {
        CC_ALW  = 3'd0,
        CC_Z    = 3'd1,
        CC_NZ   = 3'd2,
        CC_C    = 3'd3,
        CC_N    = 3'd4,
        CC_V    = 3'd5,
        CC_NEV6 = 3'd6,
        CC_NEV7 = 3'd7
    } cond_e;

    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } flags_t;

    function automatic logic cond_met(input cond_e sel, input flags_t f);
        case (sel)
            CC_ALW:  return 1'b1;
            CC_Z:    return f.z;
            CC_NZ:   return !f.z;
            CC_C:    return f.c;
            CC_N:    return f.n;
            CC_V:    return f.v;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bseq_target.sv
module bseq_target
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  tgt_mode_e            mode,
    input  logic [ADDR_W-1:0]    pc,
    input  logic [ADDR_W-1:0]    imm,
    input  logic [ADDR_W-1:0]    lnk,
    input  logic [ADDR_W-1:0]    cnt,
    output logic [ADDR_W-1:0]    target
);
    always_comb begin
        case (mode)
            TM_REL:  target = pc + imm;
            TM_ABS:  target = imm;
            TM_LNK:  target = lnk;
            default: target = cnt;
        endcase
    end
endmodule

// File: rtl/bseq_ras.sv
module bseq_ras #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_data,
    output logic [ADDR_W-1:0] top,
    output logic              full,
    output logic              empty
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   sp_m1;
    logic [ADDR_W-1:0] slots [DEPTH];

    assign full  = (sp == SP_W'(DEPTH));
    assign empty = (sp == '0);
    assign sp_m1 = sp - 1'b1;
    assign top   = slots[sp_m1[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst)
            sp <= '0;
        else if (push && !full)
            sp <= sp + 1'b1;
        else if (pop && !empty)
            sp <= sp_m1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && sp == SP_W'(g))
                slots[g] <= push_data;
        end
    end

    AST_SP_RANGE: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(DEPTH)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full |-> !push); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop); // R10

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        push |=> top == $past(push_data)); // R6

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [2:0]        req_cond,
    input  logic [1:0]        req_mode,
    input  logic [ADDR_W-1:0] req_imm,
    input  logic [3:0]        flags_in,
    input  logic              lr_we,
    input  logic [ADDR_W-1:0] lr_wdata,
    input  logic              ctr_we,
    input  logic [ADDR_W-1:0] ctr_wdata,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              taken,
    output logic              ovf_err,
    output logic              unf_err
);
    logic [ADDR_W-1:0] pc, lnk_q, cnt_q;
    logic [ADDR_W-1:0] pc_inc1, pc_inc2, tgt, ras_top, pc_nxt;
    logic              ras_full, ras_empty;
    logic              act, do_push, do_pop, ovf_hit, unf_hit;
    xfer_kind_e        kind;

    assign kind    = xfer_kind_e'(req_kind);
    assign pc_inc1 = pc + ADDR_W'(1);
    assign pc_inc2 = pc + ADDR_W'(2);
    assign act     = req_valid && cond_met(cond_e'(req_cond), flags_t'(flags_in));

    assign ovf_hit = act && kind == XK_CALL && ras_full;
    assign unf_hit = act && kind == XK_RET  && ras_empty;
    assign do_push = act && kind == XK_CALL && !ras_full;
    assign do_pop  = act && kind == XK_RET  && !ras_empty;
    assign taken   = act && !ovf_hit && !unf_hit;

    bseq_target #(.ADDR_W(ADDR_W)) u_tgt (
        .mode   (tgt_mode_e'(req_mode)),
        .pc     (pc),
        .imm    (req_imm),
        .lnk    (lnk_q),
        .cnt    (cnt_q),
        .target (tgt)
    );

    bseq_ras #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_ras (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (pc_inc1),
        .top       (ras_top),
        .full      (ras_full),
        .empty     (ras_empty)
    );

    always_comb begin
        pc_nxt = pc_inc1;
        if (taken) begin
            case (kind)
                XK_JUMP: pc_nxt = tgt;
                XK_CALL: pc_nxt = tgt;
                XK_RET:  pc_nxt = ras_top;
                default: pc_nxt = pc_inc2;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            lnk_q   <= '0;
            cnt_q   <= '0;
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            pc <= pc_nxt;
            if (lr_we)   lnk_q   <= lr_wdata;
            if (ctr_we)  cnt_q   <= ctr_wdata;
            if (ovf_hit) ovf_err <= 1'b1;
            if (unf_hit) unf_err <= 1'b1;
        end
    end

    assign fetch_addr = pc;

    AST_IDLE_SEQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> pc == ADDR_W'($past(pc) + ADDR_W'(1))); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R9

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        unf_err |=> unf_err); // R10

    AST_OVF_SEQ: assert property (@(posedge clk) disable iff (rst)
        ovf_hit |=> pc == ADDR_W'($past(pc) + ADDR_W'(1))); // R9

    AST_NO_TAKE_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !taken); // R11

endmodule

// File: tb/sim_bseq_top.sv
module sim_bseq_top;
    localparam int AW = 8;
    localparam int SD = 4;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [2:0]    req_cond = '0;
    logic [1:0]    req_mode = '0;
    logic [AW-1:0] req_imm = '0;
    logic [3:0]    flags_in = '0;
    logic          lr_we = 1'b0;
    logic [AW-1:0] lr_wdata = '0;
    logic          ctr_we = 1'b0;
    logic [AW-1:0] ctr_wdata = '0;
    logic [AW-1:0] fetch_addr;
    logic          taken, ovf_err, unf_err;

    bseq_top #(.ADDR_W(AW), .STACK_DEPTH(SD)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_cond(req_cond), .req_mode(req_mode), .req_imm(req_imm),
        .flags_in(flags_in), .lr_we(lr_we), .lr_wdata(lr_wdata),
        .ctr_we(ctr_we), .ctr_wdata(ctr_wdata), .fetch_addr(fetch_addr),
        .taken(taken), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    int m_pc = 0, m_lr = 0, m_ctr = 0, m_ovf = 0, m_unf = 0;
    int stk[$];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_cond(input int c, input int f);
        case (c)
            0: return 1;
            1: return f[0];
            2: return !f[0];
            3: return f[1];
            4: return f[2];
            5: return f[3];
            default: return 0;
        endcase
    endfunction

    // Drives one cycle at the falling edge, checks taken before the rising
    // edge and the registered state after it.
    task automatic step(input bit v, input int k, input int c, input int md,
                        input int imm, input int f,
                        input bit lwe, input int ld, input bit cwe, input int cd,
                        input string tag);
        bit act, tk;
        int nxt, tgt;
        req_valid = v; req_kind = k[1:0]; req_cond = c[2:0];
        req_mode = md[1:0]; req_imm = imm[AW-1:0]; flags_in = f[3:0];
        lr_we = lwe; lr_wdata = ld[AW-1:0]; ctr_we = cwe; ctr_wdata = cd[AW-1:0];
        #1;
        act = v && m_cond(c, f);
        case (md)
            0: tgt = (m_pc + imm) & MASK;
            1: tgt = imm & MASK;
            2: tgt = m_lr;
            default: tgt = m_ctr;
        endcase
        tk  = act;
        nxt = (m_pc + 1) & MASK;
        if (act) begin
            case (k)
                0: nxt = tgt;
                1: if (stk.size() == SD) begin tk = 0; m_ovf = 1; end
                   else begin stk.push_back((m_pc + 1) & MASK); nxt = tgt; end
                2: if (stk.size() == 0) begin tk = 0; m_unf = 1; end
                   else nxt = stk.pop_back();
                default: nxt = (m_pc + 2) & MASK;
            endcase
        end
        chk({tag, "/R11 taken"}, int'(taken), int'(tk));
        m_pc = nxt;
        if (lwe) m_lr = ld & MASK;
        if (cwe) m_ctr = cd & MASK;
        @(negedge clk);
        chk({tag, " pc"}, int'(fetch_addr), m_pc);
        chk({tag, "/R9 ovf"}, int'(ovf_err), m_ovf);
        chk({tag, "/R10 unf"}, int'(unf_err), m_unf);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 pc", int'(fetch_addr), 0);
        chk("R1 ovf", int'(ovf_err), 0);
        chk("R1 unf", int'(unf_err), 0);
        // R1: link and count registers read zero after reset
        step(1, 0, 0, 2, 0, 0, 0, 0, 0, 0, "R1 lr-zero");
        step(1, 0, 0, 3, 0, 0, 0, 0, 0, 0, "R1 ctr-zero");
        // R10 and R1: stack empty after reset
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R10 ret-empty");
        // R2: idle advance
        repeat (3) idle("R2 idle");
        // R12: loads
        step(0, 0, 0, 0, 0, 0, 1, 8'h40, 1, 8'h80, "R12 load");
        step(1, 0, 0, 2, 0, 0, 0, 0, 0, 0, "R12 R3 via-lr");
        step(1, 0, 0, 3, 0, 0, 0, 0, 0, 0, "R12 R3 via-ctr");
        // R3: absolute and relative, including wrap
        step(1, 0, 0, 1, 8'hFC, 0, 0, 0, 0, 0, "R3 abs");
        repeat (5) idle("R2 wrap");
        step(1, 0, 0, 0, 8'hFD, 0, 0, 0, 0, 0, "R3 rel-back");
        step(1, 0, 0, 0, 8'h7F, 0, 0, 0, 0, 0, "R3 rel-fwd");
        // R4 / R5: each condition with flags met and not met
        for (int c = 0; c < 8; c++) begin
            step(1, 0, c, 1, 8'h20 + c, 4'h0, 0, 0, 0, 0, "R4 R5 flags0");
            step(1, 0, c, 1, 8'h30 + c, 4'hF, 0, 0, 0, 0, "R4 R5 flagsF");
        end
        step(1, 0, 1, 1, 8'h55, 4'h1, 0, 0, 0, 0, "R4 zero-only");
        step(1, 0, 5, 1, 8'h66, 4'h8, 0, 0, 0, 0, "R4 ovf-only");
        step(1, 1, 3, 1, 8'h77, 4'h0, 0, 0, 0, 0, "R5 call-fail");
        // R6 / R9: nest calls until full, then one more
        for (int i = 0; i < SD; i++)
            step(1, 1, 0, 1, 8'h90 + 16 * i, 0, 0, 0, 0, 0, "R6 call");
        step(1, 1, 0, 1, 8'h11, 0, 0, 0, 0, 0, "R9 call-full");
        step(1, 2, 2, 1, 8'h00, 4'h1, 0, 0, 0, 0, "R5 ret-fail");
        // R7: unwind LIFO, mode fields ignored
        for (int i = 0; i < SD; i++)
            step(1, 2, 0, i % 4, 8'hEE, 0, 0, 0, 0, 0, "R7 ret");
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R10 ret-empty2");
        // R8: skip
        step(1, 3, 0, 1, 8'h99, 0, 0, 0, 0, 0, "R8 skip");
        step(1, 3, 3, 1, 8'h99, 4'h2, 0, 0, 0, 0, "R8 skip-c");
        step(1, 3, 3, 1, 8'h99, 4'h0, 0, 0, 0, 0, "R8 R5 skip-no");
        // R1: reset clears sticky errors and stack
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pc = 0; m_lr = 0; m_ctr = 0; m_ovf = 0; m_unf = 0;
        stk.delete();
        chk("R1 rst2 pc", int'(fetch_addr), 0);
        chk("R1 rst2 ovf", int'(ovf_err), 0);
        chk("R1 rst2 unf", int'(unf_err), 0);
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 3),
                 $urandom_range(0, 7), $urandom_range(0, 3),
                 $urandom_range(0, 255), $urandom_range(0, 15),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 255),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 255),
                 "R3 R6 R7 R8 mix");
            if (i % 500 == 499) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                m_pc = 0; m_lr = 0; m_ctr = 0; m_ovf = 0; m_unf = 0;
                stk.delete();
                chk("R1 mix-rst pc", int'(fetch_addr), 0);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule